// File: doc/BRIEF.md
# Switchable Slow-Mode Bus Clock Prescaler

This block derives the timing of the main internal bus from the oscillator clock. It does not gate or generate a new clock. Instead it produces a one-cycle clock-enable pulse, `bus_tick`, in the oscillator domain. Every downstream consumer, including the serial, converter and timer logic, qualifies its state updates with that single pulse. A fixed divide-by-2 stage always runs. A software-selectable divide-by-16 stage can be chained after it, which lowers the bus rate from oscillator/2 to oscillator/32 and with it the power drawn by everything that runs on the bus.

The selection is one bit (bit 1) of an 8-bit control register at bus address 0x0C. The remaining seven bits of that register are plain read/write storage for neighbouring logic. A stop-mode entry strobe clears the slow bit in hardware. A change of the selection is applied only at a divide-by-2 boundary, and the /16 counter restarts there from zero, so the bus never sees a shortened period. A status output shows the current value of the slow bit.

Top module: `bus_clock_prescaler`

## Requirements
- R1: With the slow bit clear, `bus_tick` is high for exactly one cycle in every 2 oscillator cycles.
- R2: With the slow bit set and settled, `bus_tick` is high for exactly one cycle in every 32 oscillator cycles.
- R3: A cycle with `bus_we` high and `bus_addr` equal to 0x0C loads `bus_wdata` into the control register. Bit 1 of that register is the slow-mode bit: 1 selects /32 and 0 selects /2.
- R4: A write to any other address leaves the control register and `slow_mode` unchanged.
- R5: `bus_rdata` returns the full 8-bit control register whenever `bus_addr` is 0x0C, and 0x00 for any other address.
- R6: While `rst_n` is low and after it is released, the register reads 0x10 and `slow_mode` is 0.
- R7: A high `stop_entry` clears bit 1 of the register on that clock edge and leaves the other seven bits unchanged.
- R8: When `stop_entry` coincides with a write to 0x0C, the written value is stored with bit 1 forced to 0.
- R9: A change of the slow bit is applied at the next divide-by-2 boundary with the /16 counter restarted. After a switch from /2 to /32, the tick that follows the write comes 2 cycles after the previous one and every later tick comes 32 cycles after the one before it. The bus never sees a runt period.
- R10: `slow_mode` equals bit 1 of the control register and changes in the cycle after the write that changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset (external or power-on) |
| stop_entry | input | 1 | One-cycle strobe marking entry into stop mode |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| bus_tick | output | 1 | Bus clock-enable pulse |
| slow_mode | output | 1 | Current slow-mode bit |

## Verification
The hardest case to reach is a mode switch. The slow bit can change at either phase of the divide-by-2 stage, and it can change while the /16 counter holds a leftover non-zero count from an earlier slow period. Either situation can expose a runt or stretched bus period. The stimulus switches modes repeatedly, including from slow back to normal partway through a /16 count and then to slow again. It queues the expected tick intervals at the moment of the write, so the scoreboard checks the interval across the switch as well as the steady-state periods.

// File: rtl/prescaler_pkg.sv
package prescaler_pkg;

    // Phase of the fixed divide-by-2 stage
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } half_phase_e;

    // Divide ratio currently applied to the bus
    typedef enum logic {
        RATE_FAST = 1'b0,
        RATE_SLOW = 1'b1
    } bus_rate_e;

endpackage

// File: rtl/ctrl_reg_file.sv
module ctrl_reg_file #(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR  = 8'h0C,
    parameter int                SLOW_BIT  = 1,
    parameter logic [DATA_W-1:0] RESET_VAL = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop_entry,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              slow_req
);

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
    } reg_state_t;

    reg_state_t state_d, state_q;
    logic       hit;

    always_comb begin
        hit     = (addr == REG_ADDR);
        state_d = state_q;
        if (wr_en && hit) begin
            state_d.ctrl = wdata;
        end
        // Stop entry overrides any software write of the slow bit
        if (stop_entry) begin
            state_d.ctrl[SLOW_BIT] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.ctrl <= RESET_VAL;
        end else begin
            state_q <= state_d;
        end
    end

    assign rdata    = hit ? state_q.ctrl : '0;
    assign slow_req = state_q.ctrl[SLOW_BIT];

endmodule

// File: rtl/half_rate_stage.sv
module half_rate_stage
    import prescaler_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic boundary
);

    typedef struct packed {
        half_phase_e phase;
    } half_state_t;

    half_state_t state_d, state_q;

    always_comb begin
        state_d       = state_q;
        state_d.phase = (state_q.phase == PH_LOW) ? PH_HIGH : PH_LOW;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.phase <= PH_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Last oscillator cycle of each divide-by-2 period
    assign boundary = (state_q.phase == PH_HIGH);

endmodule

// File: rtl/slow_rate_stage.sv
module slow_rate_stage
    import prescaler_pkg::*;
#(
    parameter int SLOW_DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic boundary,
    input  logic slow_req,
    output logic tick
);

    localparam int                 CNT_W    = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
    localparam logic [CNT_W-1:0]   CNT_LAST = CNT_W'(SLOW_DIV - 1);

    typedef struct packed {
        bus_rate_e        rate;
        logic [CNT_W-1:0] cnt;
    } slow_state_t;

    slow_state_t state_d, state_q;
    bus_rate_e   req_rate;

    always_comb begin
        req_rate = slow_req ? RATE_SLOW : RATE_FAST;
        state_d  = state_q;
        if (boundary) begin
            if (req_rate != state_q.rate) begin
                // Apply the new ratio only here, and restart the count
                state_d.rate = req_rate;
                state_d.cnt  = '0;
            end else if (state_q.rate == RATE_SLOW) begin
                state_d.cnt = (state_q.cnt == CNT_LAST) ? '0 : state_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.rate <= RATE_FAST;
            state_q.cnt  <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign tick = boundary &&
                  ((state_q.rate == RATE_FAST) || (state_q.cnt == CNT_LAST));

endmodule

// File: rtl/bus_clock_prescaler.sv
module bus_clock_prescaler #(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR  = 8'h0C,
    parameter int                SLOW_BIT  = 1,
    parameter int                SLOW_DIV  = 16,
    parameter logic [DATA_W-1:0] RESET_VAL = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop_entry,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_tick,
    output logic              slow_mode
);

    logic slow_req;
    logic boundary;

    ctrl_reg_file #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .REG_ADDR  (REG_ADDR),
        .SLOW_BIT  (SLOW_BIT),
        .RESET_VAL (RESET_VAL)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .stop_entry (stop_entry),
        .wr_en      (bus_we),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .rdata      (bus_rdata),
        .slow_req   (slow_req)
    );

    half_rate_stage u_half (
        .clk      (clk),
        .rst_n    (rst_n),
        .boundary (boundary)
    );

    slow_rate_stage #(
        .SLOW_DIV (SLOW_DIV)
    ) u_slow (
        .clk      (clk),
        .rst_n    (rst_n),
        .boundary (boundary),
        .slow_req (slow_req),
        .tick     (bus_tick)
    );

    assign slow_mode = slow_req;

endmodule

// File: rtl/bus_clock_prescaler_chk.sv
module bus_clock_prescaler_chk #(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h0C,
    parameter int                SLOW_BIT = 1,
    parameter int                SLOW_DIV = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop_entry,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              bus_tick,
    input logic              slow_mode
);

    localparam int MAX_GAP = 2 * SLOW_DIV;

    // Cycles since the previous tick, saturating
    logic [15:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (bus_tick) begin
            gap_q <= 16'd1;
        end else if (gap_q != 16'hFFFF) begin
            gap_q <= gap_q + 16'd1;
        end
    end

    assert_tick_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_tick |=> !bus_tick);

    assert_gap_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_tick |-> (gap_q <= 16'(MAX_GAP)));

    assert_foreign_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr != REG_ADDR && !stop_entry) |=> $stable(slow_mode));

    assert_reset_clear_R6: assert property (@(posedge clk)
        !rst_n |-> !slow_mode);

    assert_stop_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_entry |=> !slow_mode);

    assert_stop_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_entry && bus_we && bus_addr == REG_ADDR && bus_wdata[SLOW_BIT]) |=> !slow_mode);

    assert_write_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == REG_ADDR && bus_wdata[SLOW_BIT] && !stop_entry) |=> slow_mode);

endmodule

bind bus_clock_prescaler bus_clock_prescaler_chk #(
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR),
    .SLOW_BIT (SLOW_BIT),
    .SLOW_DIV (SLOW_DIV)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_entry (stop_entry),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_tick   (bus_tick),
    .slow_mode  (slow_mode)
);

// File: tb/sim_bus_clock_prescaler.sv
module sim_bus_clock_prescaler;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stop_entry = 1'b0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       bus_tick;
    logic       slow_mode;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int last_tick = -1;
    int exp_q[$];
    string tag_q[$];
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    bus_clock_prescaler u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .stop_entry (stop_entry),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_tick   (bus_tick),
        .slow_mode  (slow_mode)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: measures tick intervals and pops the expected ones
    always @(negedge clk) begin
        cyc++;
        if (bus_tick) begin
            if (last_tick >= 0 && exp_q.size() > 0) begin
                check(tag_q.pop_front(), cyc - last_tick, exp_q.pop_front());
            end
            last_tick = cyc;
        end
    end

    task automatic push(input string tag, input int period, input int n);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(period);
            tag_q.push_back(tag);
        end
    endtask

    task automatic drain();
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    task automatic wait_ticks(input int n);
        int seen = 0;
        while (seen < n) begin
            @(negedge clk);
            if (bus_tick) seen++;
        end
        @(posedge clk);
        #1;
    endtask

    // Write; expected intervals are queued right after the capturing edge
    task automatic bus_write(input logic [7:0] a, input logic [7:0] d, input logic stp,
                             input string tag, input int p1, input int n1,
                             input int p2, input int n2);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d; stop_entry = stp;
        @(posedge clk);
        #1;
        if (n1 > 0) push(tag, p1, n1);
        if (n2 > 0) push(tag, p2, n2);
        @(negedge clk);
        bus_we = 1'b0; stop_entry = 1'b0; bus_addr = 8'h0C;
    endtask

    task automatic read_check(input logic [7:0] a, input int exp, input string req);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        bus_addr = 8'h0C;
        #1;
        check("R6 reset value", bus_rdata, 8'h10);
        check("R6 slow clear", slow_mode, 0);

        push("R1 normal period", 2, 6);
        drain();

        // Normal to slow: one tick at the old rate, then the slow period
        bus_write(8'h0C, 8'h12, 1'b0, "R9 switch to slow", 2, 1, 32, 3);
        check("R10 status after write", slow_mode, 1);
        read_check(8'h0C, 8'h12, "R3 readback");
        drain();
        push("R2 slow period", 32, 2);
        drain();

        bus_write(8'h0D, 8'h00, 1'b0, "", 0, 0, 0, 0);
        check("R4 foreign write status", slow_mode, 1);
        read_check(8'h0C, 8'h12, "R4 register kept");
        read_check(8'h0D, 8'h00, "R5 other address reads zero");

        // Slow back to normal partway through a count
        wait_ticks(1);
        repeat (9) @(posedge clk);
        bus_write(8'h0C, 8'h00, 1'b0, "", 0, 0, 0, 0);
        check("R10 status clear", slow_mode, 0);
        wait_ticks(2);
        push("R9 back to normal", 2, 5);
        drain();
        // Re-enter slow with a leftover count: no runt
        bus_write(8'h0C, 8'h02, 1'b0, "R9 re-enter slow", 2, 1, 32, 2);
        drain();

        bus_write(8'h0C, 8'hF6, 1'b0, "", 0, 0, 0, 0);
        bus_write(8'h40, 8'h00, 1'b1, "", 0, 0, 0, 0);
        check("R7 stop clears status", slow_mode, 0);
        read_check(8'h0C, 8'hF4, "R7 other bits kept");
        wait_ticks(2);
        push("R1 normal after stop", 2, 4);
        drain();

        bus_write(8'h0C, 8'hAB, 1'b1, "", 0, 0, 0, 0);
        check("R8 stop wins status", slow_mode, 0);
        read_check(8'h0C, 8'hA9, "R8 stored value");

        bus_write(8'h0C, 8'h7E, 1'b0, "", 0, 0, 0, 0);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R6 reset clears status", slow_mode, 0);
        check("R6 reset value again", bus_rdata, 8'h10);
        @(negedge clk);
        rst_n = 1'b1;
        last_tick = -1;
        wait_ticks(1);
        push("R1 normal after reset", 2, 3);
        drain();

        done = 1'b1;
    end

    initial begin
        int limit = 0;
        while (!done && limit < 20000) begin
            @(posedge clk);
            limit++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", limit, 0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule